// File: doc/BRIEF.md
# Ternary Carry Look-Ahead Adder

This block adds two unsigned ternary numbers of five digits each, a width picked because five trits hold roughly as much as eight binary bits (the ratio of log 3 to log 2 is close to 1.585). Every trit is carried on a pair of binary wires, while every carry is one binary bit: the carry into the adder, the carries between stages and the carry out.

Each digit stage looks at its own two operand trits and forms a one-bit generate and a one-bit propagate. A single look-ahead network turns all generates, all propagates and the carry-in into every stage carry at once, using flat sum-of-products terms, so no carry waits on another. Each stage then forms its sum trit from its two operand trits and the carry that reaches it. The block is purely combinational. The digit count is a parameter, and the default is five.

A flag reports an operand digit that uses the one unused wire code.

Top module: `tern_cla_adder`

## Requirements
- R1: A trit is coded on two wires as 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2, with digit i of an operand at bits [2i+1:2i] (digit 0 least significant). With legal inputs, no sum digit is ever 2'b11.
- R2: A stage generates a carry exactly when its two operand digits add to 3 or more: the pairs (1,2), (2,1) and (2,2). A carry leaves that stage even when no carry enters it.
- R3: A stage propagates exactly when its two operand digits add to 2: the pairs (0,2), (1,1) and (2,0). An incoming carry then passes on, and without one no carry leaves.
- R4: Every carry is a single bit. The carry into stage i+1 equals generate(i) OR (propagate(i) AND carry into stage i), with the carry into stage 0 taken from carry_i. A carry-in can travel through all five stages to carry_o.
- R5: Sum digit i equals (A_i + B_i + carry into stage i) mod 3.
- R6: With all inputs legal, value(sum_o) + 243·carry_o = value(a_i) + value(b_i) + carry_i, where value() weights digit i by 3^i.
- R7: illegal_o is 1 exactly when some digit of a_i or b_i is 2'b11, and 0 otherwise.
- R8: The largest case, 242 + 242 + 1, gives sum 242 with carry_o = 1. All-zero inputs give a zero sum with carry_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 10 | First operand, five trits on wire pairs |
| b_i | input | 10 | Second operand, five trits on wire pairs |
| carry_i | input | 1 | Binary carry into digit 0 |
| sum_o | output | 10 | Sum, five trits on wire pairs |
| carry_o | output | 1 | Binary carry out of the top digit |
| illegal_o | output | 1 | Some operand digit is coded 2'b11 |

## Verification
The arithmetic assertions only apply to operands in which every digit uses one of the three legal codes. Each of them is gated off whenever illegal_o is high, because the outputs carry no defined meaning for the unused code. Every operand in the sweeps is built by an encoder that only ever writes 0, 1 or 2 into a digit. The 2'b11 code appears only in the directed flag tests, and those tests check illegal_o alone.

// File: rtl/tern_pkg.sv
package tern_pkg;
   localparam int TRIT_W = 2;
   typedef logic [TRIT_W-1:0] trit_t;

   localparam trit_t TRIT_ZERO = 2'b00;
   localparam trit_t TRIT_ONE  = 2'b01;
   localparam trit_t TRIT_TWO  = 2'b10;
   localparam trit_t TRIT_BAD  = 2'b11;

   // widen a trit code and a carry to a 3-bit digit total
   function automatic logic [2:0] digit_total(trit_t x, trit_t y, logic c);
      return {1'b0, x} + {1'b0, y} + {2'b00, c};
   endfunction
endpackage

// File: rtl/tern_pg_cell.sv
module tern_pg_cell
   import tern_pkg::*;
(
   input  trit_t x_i,
   input  trit_t y_i,
   output logic  gen_o,
   output logic  prop_o,
   output logic  bad_o
);
   logic [2:0] pair_sum;

   always_comb begin
      pair_sum = digit_total(x_i, y_i, 1'b0);
      gen_o    = (pair_sum >= 3'd3);
      prop_o   = (pair_sum == 3'd2);
      bad_o    = (x_i == TRIT_BAD) || (y_i == TRIT_BAD);
   end

   always_comb begin
      if (!bad_o && gen_o)
         AST_GEN_HAS_TWO: assert (x_i == TRIT_TWO || y_i == TRIT_TWO); // R2
      if (!bad_o && prop_o)
         AST_PROP_NO_GEN: assert (!gen_o && (x_i != TRIT_ZERO || y_i == TRIT_TWO)); // R3
   end
endmodule

// File: rtl/tern_carry_lookahead.sv
module tern_carry_lookahead #(
   parameter int N_STAGES = 5
) (
   input  logic [N_STAGES-1:0] gen_i,
   input  logic [N_STAGES-1:0] prop_i,
   input  logic                cin_i,
   output logic [N_STAGES:0]   carry_o
);
   assign carry_o[0] = cin_i;

   for (genvar i = 0; i < N_STAGES; i++) begin : g_carry
      // flat sum of products: every term starts at a generate or at cin
      always_comb begin
         logic term;
         logic acc;
         acc = 1'b0;
         for (int j = 0; j <= i; j++) begin
            term = gen_i[j];
            for (int k = j + 1; k <= i; k++) term = term & prop_i[k];
            acc = acc | term;
         end
         term = cin_i;
         for (int k = 0; k <= i; k++) term = term & prop_i[k];
         carry_o[i+1] = acc | term;
      end

      always_comb begin
         AST_CARRY_STEP: assert (carry_o[i+1] == (gen_i[i] | (prop_i[i] & carry_o[i]))); // R4
      end
   end
endmodule

// File: rtl/tern_sum_cell.sv
module tern_sum_cell
   import tern_pkg::*;
(
   input  trit_t x_i,
   input  trit_t y_i,
   input  logic  cin_i,
   output trit_t sum_o
);
   logic [2:0] tot;

   always_comb begin
      tot = digit_total(x_i, y_i, cin_i);
      unique case (tot)
         3'd0, 3'd3, 3'd6: sum_o = TRIT_ZERO;
         3'd1, 3'd4, 3'd7: sum_o = TRIT_ONE;
         default:          sum_o = TRIT_TWO;
      endcase
   end
endmodule

// File: rtl/tern_cla_adder.sv
module tern_cla_adder
   import tern_pkg::*;
#(
   parameter int NUM_TRITS = 5
) (
   input  logic [NUM_TRITS*TRIT_W-1:0] a_i,
   input  logic [NUM_TRITS*TRIT_W-1:0] b_i,
   input  logic                        carry_i,
   output logic [NUM_TRITS*TRIT_W-1:0] sum_o,
   output logic                        carry_o,
   output logic                        illegal_o
);
   localparam int BUS_W = NUM_TRITS * TRIT_W;

   if (NUM_TRITS < 1 || NUM_TRITS > 20) begin : g_bad_width
      $error("tern_cla_adder: NUM_TRITS must be within 1..20");
   end

   logic [NUM_TRITS-1:0] gen, prop, bad;
   logic [NUM_TRITS:0]   carry;

   for (genvar i = 0; i < NUM_TRITS; i++) begin : g_stage
      tern_pg_cell u_pg (
         .x_i    (a_i[i*TRIT_W +: TRIT_W]),
         .y_i    (b_i[i*TRIT_W +: TRIT_W]),
         .gen_o  (gen[i]),
         .prop_o (prop[i]),
         .bad_o  (bad[i])
      );
      tern_sum_cell u_sum (
         .x_i   (a_i[i*TRIT_W +: TRIT_W]),
         .y_i   (b_i[i*TRIT_W +: TRIT_W]),
         .cin_i (carry[i]),
         .sum_o (sum_o[i*TRIT_W +: TRIT_W])
      );
   end

   tern_carry_lookahead #(.N_STAGES(NUM_TRITS)) u_cla (
      .gen_i   (gen),
      .prop_i  (prop),
      .cin_i   (carry_i),
      .carry_o (carry)
   );

   assign carry_o   = carry[NUM_TRITS];
   assign illegal_o = |bad;

   always_comb begin
      longint unsigned va, vb, vs, w;
      va = 0; vb = 0; vs = 0; w = 1;
      for (int i = 0; i < NUM_TRITS; i++) begin
         va += longint'(a_i[i*TRIT_W +: TRIT_W]) * w;
         vb += longint'(b_i[i*TRIT_W +: TRIT_W]) * w;
         vs += longint'(sum_o[i*TRIT_W +: TRIT_W]) * w;
         w  *= 3;
         if (!illegal_o) begin
            AST_SUM_CODE: assert (sum_o[i*TRIT_W +: TRIT_W] != TRIT_BAD); // R1
            AST_DIGIT_MOD: assert ((32'(sum_o[i*TRIT_W +: TRIT_W]) + 3 * 32'(carry[i+1]))
                                   == (32'(a_i[i*TRIT_W +: TRIT_W]) + 32'(b_i[i*TRIT_W +: TRIT_W])
                                       + 32'(carry[i]))); // R5
         end
      end
      if (!illegal_o)
         AST_TOTAL: assert (vs + w * longint'(carry_o) == va + vb + longint'(carry_i)); // R6
   end

   logic unused_bus;
   assign unused_bus = ^BUS_W;
endmodule

// File: tb/sim_tern_cla_adder.sv
module sim_tern_cla_adder;
   localparam int NT = 5;
   localparam int MAXV = 243;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [2*NT-1:0] a, b, s;
   logic cin, cout, bad;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   tern_cla_adder #(.NUM_TRITS(NT)) u0 (
      .a_i(a), .b_i(b), .carry_i(cin),
      .sum_o(s), .carry_o(cout), .illegal_o(bad)
   );

   function automatic logic [2*NT-1:0] enc(int v);
      logic [2*NT-1:0] r;
      int x;
      x = v;
      for (int i = 0; i < NT; i++) begin
         r[2*i +: 2] = 2'(x % 3);
         x = x / 3;
      end
      return r;
   endfunction

   function automatic int dec(logic [2*NT-1:0] v);
      int r;
      int w;
      r = 0; w = 1;
      for (int i = 0; i < NT; i++) begin
         r += int'(v[2*i +: 2]) * w;
         w *= 3;
      end
      return r;
   endfunction

   function automatic int p3(int k);
      int r;
      r = 1;
      for (int i = 0; i < k; i++) r *= 3;
      return r;
   endfunction

   task automatic check(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d (a=%0d b=%0d cin=%0d)",
                  tag, got, exp, dec(a), dec(b), cin);
      end
   endtask

   // drives legal operands and checks the weighted total and the flag
   task automatic add_case(string tag, int va, int vb, logic ci);
      int tot;
      int digs_ok;
      a = enc(va); b = enc(vb); cin = ci;
      #1;
      tot = va + vb + int'(ci);
      check(tag, dec(s) + MAXV * int'(cout), tot);
      check({tag, "/R7"}, int'(bad), 0);
      digs_ok = 1;
      for (int i = 0; i < NT; i++) if (s[2*i +: 2] == 2'b11) digs_ok = 0;
      check({tag, "/R1"}, digs_ok, 1);
   endtask

   initial begin : watchdog
      while (!done && cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      a = '0; b = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R8: zero inputs
      check("R8 zero sum", dec(s), 0);
      check("R8 zero carry", int'(cout), 0);
      check("R7 zero flag", int'(bad), 0);

      // R8: largest operands with carry-in
      add_case("R8 max", 242, 242, 1'b1);
      check("R8 max sum", dec(s), 242);
      check("R8 max carry", int'(cout), 1);

      // R2: generate pairs at every position, no incoming carry
      for (int k = 0; k < NT; k++)
         for (int x = 0; x < 3; x++)
            for (int y = 0; y < 3; y++)
               add_case("R2 generate", x * p3(k), y * p3(k), 1'b0);

      // R3: lower stages propagate a carry-in up to position k
      for (int k = 0; k < NT; k++)
         for (int x = 0; x < 3; x++)
            for (int y = 0; y < 3; y++) begin
               int low;
               low = (p3(k) - 1) / 2;
               add_case("R3 propagate", x * p3(k) + low, y * p3(k) + low, 1'b1);
            end

      // R4: full-length propagate chain, carry-in on and off
      add_case("R4 chain in", 121, 121, 1'b1);
      check("R4 chain carry", int'(cout), 1);
      check("R4 chain sum", dec(s), 0);
      add_case("R4 chain off", 121, 121, 1'b0);
      check("R4 chain hold", int'(cout), 0);

      // R5: per-digit modulo
      add_case("R5 digits", 200, 100, 1'b1);
      for (int i = 0; i < NT; i++) begin
         int exp_d, cc, ta, tb;
         cc = 1;
         for (int j = 0; j <= i; j++) begin
            ta = (200 / p3(j)) % 3;
            tb = (100 / p3(j)) % 3;
            exp_d = (ta + tb + cc) % 3;
            cc = (ta + tb + cc) >= 3 ? 1 : 0;
         end
         check("R5 digit", int'(s[2*i +: 2]), exp_d);
      end

      // R7: illegal code in each digit of each operand
      for (int k = 0; k < NT; k++) begin
         a = enc(0); b = enc(0); cin = 1'b0;
         a[2*k +: 2] = 2'b11;
         #1 check("R7 flag a", int'(bad), 1);
         a = enc(0);
         b[2*k +: 2] = 2'b11;
         #1 check("R7 flag b", int'(bad), 1);
      end

      // R6: exhaustive sweep of both operands and carry-in
      for (int x = 0; x < MAXV; x++)
         for (int y = 0; y < MAXV; y++)
            for (int c = 0; c < 2; c++)
               add_case("R6 sweep", x, y, c[0]);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule